// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns the processor's low-power mode selection into six enables: one for the CPU core, three for the gated clocks (main, sub-main and auxiliary), one for the DCO DC generator and one for the crystal oscillator. The processor writes a four-bit mode word. The controller holds that mode until an enabled interrupt is accepted. It then drops back to active mode so the handler can run. When the handler returns, the controller restores the mode that was in force before the interrupt.

After power-up the processor fetches the reset vector. If that first fetch returns an erased word, the controller parks the device in the deepest mode at once. Clock enables never change in the middle of a clock's high phase. A gated-clock enable updates only in a cycle that the clock source marks as its falling edge, so the gate cannot produce a shortened pulse. The generator and oscillator enables have no clock to protect, so they follow the mode one cycle after it changes.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After a synchronous reset all six enables are high, the stored mode and the save register are cleared, and the reset-vector check is armed.
- R2: Mode bit 0 (CPU off) clears both cpu_en and mclk_en; with bit 0 low, both are high.
- R3: Mode bit 3 (generator-1 off) clears smclk_en. Mode bit 1 (oscillator off) clears both aclk_en and xtal_en.
- R4: dcogen_en is low when mode bit 2 (generator-0 off) is set together with either mode bit 3 or a low dco_in_use; it is high in every other case.
- R5: A mode write is ignored while the current mode has bit 0 (CPU off) set.
- R6: irq_enter copies the current mode into the one-entry save register and makes the current mode active (all bits zero).
- R7: irq_ret loads the current mode from the save register.
- R8: The first rv_valid strobe after reset forces mode 4'b1111 (deepest mode) when rv_word is 16'hFFFF. A first strobe with any other word leaves the mode alone, and every later strobe is ignored.
- R9: cpu_en, mclk_en, smclk_en and aclk_en change only in a cycle whose matching falling-edge marker (mclk_fall, smclk_fall or aclk_fall) is high. dcogen_en and xtal_en follow a mode change one cycle after it.
- R10: When several events arrive in the same cycle, irq_enter wins over irq_ret, irq_ret wins over the reset-vector force, and the force wins over a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| dco_in_use | input | 1 | DCO drives some clock in active mode |
| mode_wr | input | 1 | Mode write strobe from the CPU |
| mode_bits | input | 4 | Mode word: bit0 CPU off, bit1 osc off, bit2 gen-0 off, bit3 gen-1 off |
| irq_enter | input | 1 | Enabled interrupt accepted |
| irq_ret | input | 1 | Return from interrupt handler |
| rv_valid | input | 1 | Reset vector word is valid |
| rv_word | input | VEC_W | Fetched reset vector word |
| mclk_fall | input | 1 | Falling-edge marker of the main clock source |
| smclk_fall | input | 1 | Falling-edge marker of the sub-main clock source |
| aclk_fall | input | 1 | Falling-edge marker of the auxiliary clock source |
| cpu_en | output | 1 | CPU core enable |
| mclk_en | output | 1 | Main clock gate enable |
| smclk_en | output | 1 | Sub-main clock gate enable |
| aclk_en | output | 1 | Auxiliary clock gate enable |
| dcogen_en | output | 1 | DCO DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The wake and blank-vector properties check the generator and oscillator enables two cycles after the triggering strobe. They therefore assume that no mode write, return or second strobe arrives in the cycle right after it. The stimulus spaces every event at least three cycles apart, except in the deliberate same-cycle priority cases. The falling-edge properties assume that a marker is a plain level sampled at the controller clock. The bench holds the markers high, except where it holds one low to prove that its enable waits.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 4;
  localparam int GATE_N = 3;
  localparam int G_MCLK  = 0;
  localparam int G_SMCLK = 1;
  localparam int G_ACLK  = 2;

  typedef struct packed {
    logic gen1_off;
    logic gen0_off;
    logic osc_off;
    logic cpu_off;
  } lpm_mode_t;

  localparam lpm_mode_t MODE_ACTIVE = '0;
  localparam lpm_mode_t MODE_DEEP   = '1;
endpackage

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] BLANK_VEC = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  lpm_mode_t        mode_in,
  input  logic             irq_enter,
  input  logic             irq_ret,
  input  logic             rv_valid,
  input  logic [VEC_W-1:0] rv_word,
  output lpm_mode_t        cur_mode
);
  lpm_mode_t saved_mode;
  logic      boot_armed;
  logic      blank_hit;

  assign blank_hit = rv_valid && boot_armed && (rv_word == BLANK_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode   <= MODE_ACTIVE;
      saved_mode <= MODE_ACTIVE;
      boot_armed <= 1'b1;
    end else begin
      if (rv_valid) boot_armed <= 1'b0;
      if (irq_enter) begin
        saved_mode <= cur_mode;
        cur_mode   <= MODE_ACTIVE;
      end else if (irq_ret) begin
        cur_mode <= saved_mode;
      end else if (blank_hit) begin
        cur_mode <= MODE_DEEP;
      end else if (mode_wr && !cur_mode.cpu_off) begin
        cur_mode <= mode_in;
      end
    end
  end
endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
  import lpm_pkg::*;
(
  input  lpm_mode_t         mode,
  input  logic              dco_in_use,
  output logic [GATE_N-1:0] gate_req,
  output logic              gen_req,
  output logic              xtal_req
);
  always_comb begin
    gate_req          = '0;
    gate_req[G_MCLK]  = !mode.cpu_off;
    gate_req[G_SMCLK] = !mode.gen1_off;
    gate_req[G_ACLK]  = !mode.osc_off;
    gen_req  = !(mode.gen0_off && (mode.gen1_off || !dco_in_use));
    xtal_req = !mode.osc_off;
  end
endmodule

// File: rtl/lpm_edge_gate.sv
module lpm_edge_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] fall,
  output logic [N-1:0] en
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst)          en[g] <= 1'b1;
      else if (fall[g]) en[g] <= req[g];
    end
  end
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] BLANK_VEC = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dco_in_use,
  input  logic             mode_wr,
  input  logic [3:0]       mode_bits,
  input  logic             irq_enter,
  input  logic             irq_ret,
  input  logic             rv_valid,
  input  logic [VEC_W-1:0] rv_word,
  input  logic             mclk_fall,
  input  logic             smclk_fall,
  input  logic             aclk_fall,
  output logic             cpu_en,
  output logic             mclk_en,
  output logic             smclk_en,
  output logic             aclk_en,
  output logic             dcogen_en,
  output logic             xtal_en
);
  lpm_mode_t         cur_mode;
  logic [GATE_N-1:0] gate_req;
  logic [GATE_N-1:0] gate_fall;
  logic [GATE_N-1:0] gate_en;
  logic              gen_req;
  logic              xtal_req;

  lpm_mode_reg #(.VEC_W(VEC_W), .BLANK_VEC(BLANK_VEC)) u_mode (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(lpm_mode_t'(mode_bits)),
    .irq_enter(irq_enter), .irq_ret(irq_ret), .rv_valid(rv_valid),
    .rv_word(rv_word), .cur_mode(cur_mode)
  );

  lpm_decode u_dec (
    .mode(cur_mode), .dco_in_use(dco_in_use), .gate_req(gate_req),
    .gen_req(gen_req), .xtal_req(xtal_req)
  );

  always_comb begin
    gate_fall          = '0;
    gate_fall[G_MCLK]  = mclk_fall;
    gate_fall[G_SMCLK] = smclk_fall;
    gate_fall[G_ACLK]  = aclk_fall;
  end

  lpm_edge_gate #(.N(GATE_N)) u_gate (
    .clk(clk), .rst(rst), .req(gate_req), .fall(gate_fall), .en(gate_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dcogen_en <= 1'b1;
      xtal_en   <= 1'b1;
    end else begin
      dcogen_en <= gen_req;
      xtal_en   <= xtal_req;
    end
  end

  assign cpu_en   = gate_en[G_MCLK];
  assign mclk_en  = gate_en[G_MCLK];
  assign smclk_en = gate_en[G_SMCLK];
  assign aclk_en  = gate_en[G_ACLK];
endmodule

// File: rtl/lpm_clock_ctrl_chk.sv
module lpm_clock_ctrl_chk #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] BLANK_VEC = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_enter,
  input logic             irq_ret,
  input logic             rv_valid,
  input logic [VEC_W-1:0] rv_word,
  input logic             mclk_fall,
  input logic             smclk_fall,
  input logic             aclk_fall,
  input logic             cpu_en,
  input logic             mclk_en,
  input logic             smclk_en,
  input logic             aclk_en,
  input logic             dcogen_en,
  input logic             xtal_en
);
  logic seen_rv;
  always_ff @(posedge clk) begin
    if (rst)           seen_rv <= 1'b0;
    else if (rv_valid) seen_rv <= 1'b1;
  end

  AST_RESET_ACTIVE: assert property (@(posedge clk)
    rst |=> (cpu_en && mclk_en && smclk_en && aclk_en && dcogen_en && xtal_en)); // R1

  AST_MCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mclk_en) |-> ($past(mclk_fall) || $past(rst))); // R9

  AST_SMCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(smclk_en) |-> ($past(smclk_fall) || $past(rst))); // R9

  AST_ACLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(aclk_en) |-> ($past(aclk_fall) || $past(rst))); // R9

  AST_WAKE_GENERATORS: assert property (@(posedge clk) disable iff (rst)
    irq_enter |=> ##1 (dcogen_en && xtal_en)); // R6

  AST_BLANK_VECTOR_DEEP: assert property (@(posedge clk) disable iff (rst)
    (rv_valid && !seen_rv && (rv_word == BLANK_VEC) && !irq_enter && !irq_ret)
      |=> ##1 (!dcogen_en && !xtal_en)); // R8
endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk #(.VEC_W(VEC_W), .BLANK_VEC(BLANK_VEC)) u_chk (
  .clk(clk), .rst(rst), .irq_enter(irq_enter), .irq_ret(irq_ret),
  .rv_valid(rv_valid), .rv_word(rv_word), .mclk_fall(mclk_fall),
  .smclk_fall(smclk_fall), .aclk_fall(aclk_fall), .cpu_en(cpu_en),
  .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
  .dcogen_en(dcogen_en), .xtal_en(xtal_en)
);

// File: tb/lpm_clock_ctrl_test.sv
module lpm_clock_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dco_in_use = 1'b0;
  logic mode_wr = 1'b0;
  logic [3:0] mode_bits = 4'h0;
  logic irq_enter = 1'b0;
  logic irq_ret = 1'b0;
  logic rv_valid = 1'b0;
  logic [15:0] rv_word = 16'h0;
  logic mclk_fall = 1'b1;
  logic smclk_fall = 1'b1;
  logic aclk_fall = 1'b1;
  logic cpu_en, mclk_en, smclk_en, aclk_en, dcogen_en, xtal_en;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lpm_clock_ctrl uut (
    .clk(clk), .rst(rst), .dco_in_use(dco_in_use), .mode_wr(mode_wr),
    .mode_bits(mode_bits), .irq_enter(irq_enter), .irq_ret(irq_ret),
    .rv_valid(rv_valid), .rv_word(rv_word), .mclk_fall(mclk_fall),
    .smclk_fall(smclk_fall), .aclk_fall(aclk_fall), .cpu_en(cpu_en),
    .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
    .dcogen_en(dcogen_en), .xtal_en(xtal_en)
  );

  // order: cpu, mclk, smclk, aclk, dcogen, xtal
  function automatic logic [5:0] exp_en(input logic [3:0] b, input logic dco);
    logic gen;
    gen = !(b[2] && (b[3] || !dco));
    return {!b[0], !b[0], !b[3], !b[1], gen, !b[1]};
  endfunction

  task automatic chk(input string tag, input logic [5:0] mask, input logic [5:0] exp);
    logic [5:0] act;
    act = {cpu_en, mclk_en, smclk_en, aclk_en, dcogen_en, xtal_en};
    n_checks++;
    if ((act & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (mask %b)", tag, act, exp, mask);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mode_wr = 0; irq_enter = 0; irq_ret = 0; rv_valid = 0;
    mclk_fall = 1; smclk_fall = 1; aclk_fall = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic w, input logic [3:0] b, input logic e,
                      input logic r, input logic v, input logic [15:0] word);
    @(negedge clk);
    mode_wr = w; mode_bits = b; irq_enter = e; irq_ret = r; rv_valid = v; rv_word = word;
    @(negedge clk);
    mode_wr = 0; irq_enter = 0; irq_ret = 0; rv_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 reset state", 6'b111111, 6'b111111);

    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] b;
        b = 4'(m);
        do_reset();
        dco_in_use = d[0];
        step(1, b, 0, 0, 0, 16'h0);
        chk("R2 cpu/mclk", 6'b110000, exp_en(b, d[0]));
        chk("R3 smclk/aclk/xtal", 6'b001101, exp_en(b, d[0]));
        chk("R4 dco generator", 6'b000010, exp_en(b, d[0]));
        if (b[0]) begin
          step(1, 4'h0, 0, 0, 0, 16'h0);
          chk("R5 write ignored while cpu off", 6'b111111, exp_en(b, d[0]));
        end
        step(0, 4'h0, 1, 0, 0, 16'h0);
        chk("R6 wake to active", 6'b111111, 6'b111111);
        step(0, 4'h0, 0, 1, 0, 16'h0);
        chk("R7 restore saved mode", 6'b111111, exp_en(b, d[0]));
      end
    end

    dco_in_use = 1'b0;
    do_reset();
    step(0, 4'h0, 0, 0, 1, 16'hFFFF);
    chk("R8 blank vector forces deep mode", 6'b111111, 6'b000000);
    do_reset();
    step(0, 4'h0, 0, 0, 1, 16'h1234);
    chk("R8 programmed vector keeps active", 6'b111111, 6'b111111);
    step(0, 4'h0, 0, 0, 1, 16'hFFFF);
    chk("R8 later strobe ignored", 6'b111111, 6'b111111);

    do_reset();
    mclk_fall = 1'b0;
    step(1, 4'b0001, 0, 0, 0, 16'h0);
    repeat (4) @(negedge clk);
    chk("R9 mclk waits for falling edge", 6'b110000, 6'b110000);
    mclk_fall = 1'b1;
    @(negedge clk);
    chk("R9 mclk gated on falling edge", 6'b110000, 6'b000000);

    do_reset();
    aclk_fall = 1'b0;
    step(1, 4'b0010, 0, 0, 0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R9 xtal off, aclk held", 6'b000101, 6'b000100);
    aclk_fall = 1'b1;
    @(negedge clk);
    chk("R9 aclk gated on falling edge", 6'b000100, 6'b000000);

    do_reset();
    smclk_fall = 1'b0;
    step(1, 4'b1001, 0, 0, 0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R9 smclk waits for falling edge", 6'b001000, 6'b001000);
    smclk_fall = 1'b1;
    @(negedge clk);
    chk("R9 smclk gated on falling edge", 6'b001000, 6'b000000);

    do_reset();
    step(1, 4'b0001, 0, 0, 0, 16'h0);
    step(0, 4'h0, 1, 1, 0, 16'h0);
    chk("R10 enter beats return", 6'b111111, 6'b111111);
    step(1, 4'b1001, 0, 1, 0, 16'h0);
    chk("R10 return beats mode write", 6'b111111, exp_en(4'b0001, 1'b0));
    do_reset();
    step(1, 4'b0010, 0, 0, 1, 16'hFFFF);
    chk("R10 blank force beats mode write", 6'b111111, 6'b000000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule